// File: doc/BRIEF.md
# Linked-descriptor DMA chain engine

This block walks a chain of transfer descriptors held in memory. Each descriptor covers one frame. Software places the byte address of the first descriptor in the chain-head register and then sets the run bit. The engine reads the descriptor's four words over a word-wide memory request port. It hands the buffer pointer and byte length to an external frame mover and waits for that mover to report completion. It then writes the mover's status into the descriptor and clears the descriptor's ownership bit, so the descriptor goes back to software.

The next step depends on three control bits in word 0 of a descriptor. Bit 31 is VALID, meaning the engine owns the descriptor. Bit 30 is LINK, meaning follow word 2 to a further descriptor. Bit 29 is POLL, meaning keep re-reading a linked descriptor that is not yet valid. Bits 15:0 hold the length. Word 1 is the buffer pointer, word 2 is the byte address of the next descriptor, and word 3 receives the status.

From these bits the engine chains to the next descriptor, stops, or re-polls a descriptor that is still owned by software. The three outcomes raise three sticky interrupt flags, each with its own mask bit. A ring of descriptors can be built once and serviced with a single start command.

Software registers are selected by `reg_addr`:

| Index | Register | Meaning |
|---|---|---|
| 0 | chain head | byte address of the first descriptor |
| 1 | run | bit 0 is run, bit 1 reads busy |
| 2 | poll gap | poll interval in cycles |
| 3 | flags | bit 0 frame-done, bit 1 next-invalid, bit 2 chain-done; write 1 to clear |
| 4 | mask | one enable bit for each flag |

Streams use valid/ready. A memory request is accepted in a cycle with `mem_req_valid` and `mem_req_ready` both high. While it waits, the request holds its address, direction and data stable. At most one read is outstanding. Its data returns on `mem_rsp_valid`, which the engine always accepts and which carries no ready. Writes have no response. The frame-start request behaves in the same way, holding pointer and length until `fm_start_ready` is high. The done report is taken in a cycle with `fm_done_valid` and `fm_done_ready` both high, and `fm_done_ready` is high only while a frame is in flight.

Top module: `dchain_dma`

## Requirements
- R1: After reset the engine makes no memory or frame-start request, every register reads 0 and `irq` is low. While the run bit is 0 the engine stays idle. When run is 1 in the idle state, it reads word 0 at the chain-head address.
- R2: For a descriptor with bit 31 set, the engine reads words 1 and 2 and then issues one frame start. The start carries `fm_buf_ptr` = word 1 and `fm_len` = word 0 bits 15:0. Frames start in link order, and each next descriptor is found at the byte address in word 2.
- R3: After the frame-done handshake, the engine writes the 16-bit status, zero-extended, to word 3 (address +12). It then writes word 0 with bit 31 cleared and every other bit unchanged, and sets flag bit 0 (frame-done).
- R4: A completed descriptor with bit 30 clear also sets flag bit 2 (chain-done) in the same cycle, and the engine returns to idle.
- R5: If a linked descriptor reads with bit 31 clear and the linking descriptor's bit 29 is 0, the engine sets flag bits 1 and 2, starts no frame and writes nothing to that descriptor.
- R6: If a linked descriptor reads invalid and the linking descriptor's bit 29 is 1, the engine waits for the poll gap (in cycles) and then re-reads word 0. Each invalid read sets flag bit 1. Once the descriptor reads valid, processing resumes without a new start command.
- R7: A first descriptor that reads invalid is handled by the rules of R5 and R6, using bit 29 of its own word 0.
- R8: The run bit clears itself in the cycle in which chain-done is raised. Run register bit 1 reads 1 while the engine is not idle.
- R9: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: `irq` is the OR over the three flags of each flag ANDed with its mask bit.
- R11: A memory request or frame start that is not accepted keeps its valid signal high and its fields stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_addr |
| mem_req_valid | output | 1 | memory request valid |
| mem_req_ready | input | 1 | memory request ready |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | byte address of the word |
| mem_req_wdata | output | 32 | write data |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_data | input | 32 | read data |
| fm_start_valid | output | 1 | frame start valid |
| fm_start_ready | input | 1 | frame mover accepts start |
| fm_buf_ptr | output | AW | frame buffer pointer |
| fm_len | output | 16 | frame byte length |
| fm_done_valid | input | 1 | frame done valid |
| fm_done_ready | output | 1 | engine waits for frame done |
| fm_done_status | input | 16 | frame status |
| irq | output | 1 | masked interrupt |

## Verification
A wrong walker state shows up within a few cycles at the memory port. It appears as a read of the wrong descriptor word, a write-back to the wrong address, or a word 0 written back with its ownership bit still set. It can also appear as a frame start whose pointer or length differs from the descriptor. A wrong chaining or polling decision appears as frames out of link order, a frame from a descriptor that was still invalid, missing or extra re-reads of a polled descriptor, or a flag pattern that differs from the expected one when chain-done is raised. Faults in the flags or masks show on the next register read or directly on `irq`.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int DW        = 32;
  localparam int LEN_W     = 16;
  localparam int STAT_W    = 16;
  localparam int NIRQ      = 3;
  localparam int VALID_BIT = 31;
  localparam int LINK_BIT  = 30;
  localparam int POLL_BIT  = 29;

  localparam int IRQ_FRAME = 0;
  localparam int IRQ_NINV  = 1;
  localparam int IRQ_CHAIN = 2;

  localparam logic [2:0] REG_HEAD = 3'd0;
  localparam logic [2:0] REG_RUN  = 3'd1;
  localparam logic [2:0] REG_GAP  = 3'd2;
  localparam logic [2:0] REG_FLAG = 3'd3;
  localparam logic [2:0] REG_MASK = 3'd4;

  typedef enum logic [2:0] {
    W_IDLE, W_RDREQ, W_RDWAIT, W_MOVE, W_FRAME, W_WSTAT, W_WCTRL, W_GAP
  } walk_state_t;
endpackage

// File: rtl/dchain_irq.sv
module dchain_irq
  import dchain_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] ev,
  input  logic [NIRQ-1:0] clr,
  input  logic [NIRQ-1:0] en,
  output logic [NIRQ-1:0] flags,
  output logic            irq
);
  for (genvar i = 0; i < NIRQ; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= ev[i] | (flags[i] & ~clr[i]);
    end
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/dchain_csr.sv
module dchain_csr
  import dchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             run_clr,
  input  logic             busy,
  input  logic [NIRQ-1:0]  flags,
  output logic [AW-1:0]    head_ptr,
  output logic             run,
  output logic [GAP_W-1:0] poll_gap,
  output logic [NIRQ-1:0]  irq_en,
  output logic [NIRQ-1:0]  flag_clr
);
  logic wr_head, wr_run, wr_gap, wr_mask;

  always_comb begin
    wr_head  = reg_we && (reg_addr == REG_HEAD);
    wr_run   = reg_we && (reg_addr == REG_RUN);
    wr_gap   = reg_we && (reg_addr == REG_GAP);
    wr_mask  = reg_we && (reg_addr == REG_MASK);
    flag_clr = (reg_we && (reg_addr == REG_FLAG)) ? reg_wdata[NIRQ-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      run      <= 1'b0;
      poll_gap <= '0;
      irq_en   <= '0;
    end else begin
      if (wr_head) head_ptr <= reg_wdata[AW-1:0];
      if (wr_gap)  poll_gap <= reg_wdata[GAP_W-1:0];
      if (wr_mask) irq_en   <= reg_wdata[NIRQ-1:0];
      if (wr_run)       run <= reg_wdata[0];
      else if (run_clr) run <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_HEAD: reg_rdata = DW'(head_ptr);
      REG_RUN:  reg_rdata = DW'({busy, run});
      REG_GAP:  reg_rdata = DW'(poll_gap);
      REG_FLAG: reg_rdata = DW'(flags);
      REG_MASK: reg_rdata = DW'(irq_en);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
  import dchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int GAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [AW-1:0]     head_ptr,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              fm_start_valid,
  input  logic              fm_start_ready,
  output logic [AW-1:0]     fm_buf_ptr,
  output logic [LEN_W-1:0]  fm_len,
  input  logic              fm_done_valid,
  output logic              fm_done_ready,
  input  logic [STAT_W-1:0] fm_done_status,
  output logic [NIRQ-1:0]   ev,
  output logic              busy
);
  localparam logic [AW-1:0] OFS_STAT = AW'(12);

  walk_state_t       state;
  logic [AW-1:0]     base_q;
  logic [1:0]        widx_q;
  logic [DW-1:0]     ctrl_q;
  logic [AW-1:0]     buf_q;
  logic [AW-1:0]     link_q;
  logic [STAT_W-1:0] stat_q;
  logic              first_q;
  logic              poll_link_q;
  logic [GAP_W-1:0]  gap_cnt;

  logic rsp_w0, inv_seen, poll_now, wctrl_acc;

  always_comb begin
    rsp_w0    = (state == W_RDWAIT) && mem_rsp_valid && (widx_q == 2'd0);
    inv_seen  = rsp_w0 && !mem_rsp_data[VALID_BIT];
    poll_now  = first_q ? mem_rsp_data[POLL_BIT] : poll_link_q;
    wctrl_acc = (state == W_WCTRL) && mem_req_ready;
    ev            = '0;
    ev[IRQ_FRAME] = wctrl_acc;
    ev[IRQ_NINV]  = inv_seen;
    ev[IRQ_CHAIN] = (inv_seen && !poll_now) || (wctrl_acc && !ctrl_q[LINK_BIT]);
  end

  always_comb begin
    mem_req_valid = (state == W_RDREQ) || (state == W_WSTAT) || (state == W_WCTRL);
    mem_req_write = (state == W_WSTAT) || (state == W_WCTRL);
    case (state)
      W_WSTAT: mem_req_addr = base_q + OFS_STAT;
      W_WCTRL: mem_req_addr = base_q;
      default: mem_req_addr = base_q + AW'({widx_q, 2'b00});
    endcase
    if (state == W_WSTAT) mem_req_wdata = DW'(stat_q);
    else begin
      mem_req_wdata            = ctrl_q;
      mem_req_wdata[VALID_BIT] = 1'b0;
    end
    fm_start_valid = (state == W_MOVE);
    fm_done_ready  = (state == W_FRAME);
    fm_buf_ptr     = buf_q;
    fm_len         = ctrl_q[LEN_W-1:0];
    busy           = (state != W_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= W_IDLE;
      base_q      <= '0;
      widx_q      <= '0;
      ctrl_q      <= '0;
      buf_q       <= '0;
      link_q      <= '0;
      stat_q      <= '0;
      first_q     <= 1'b0;
      poll_link_q <= 1'b0;
      gap_cnt     <= '0;
    end else begin
      case (state)
        W_IDLE: if (run) begin
          base_q  <= head_ptr;
          widx_q  <= 2'd0;
          first_q <= 1'b1;
          state   <= W_RDREQ;
        end
        W_RDREQ: if (mem_req_ready) state <= W_RDWAIT;
        W_RDWAIT: if (mem_rsp_valid) begin
          case (widx_q)
            2'd0: begin
              if (mem_rsp_data[VALID_BIT]) begin
                ctrl_q <= mem_rsp_data;
                widx_q <= 2'd1;
                state  <= W_RDREQ;
              end else if (poll_now) begin
                gap_cnt <= poll_gap;
                state   <= W_GAP;
              end else begin
                state <= W_IDLE;
              end
            end
            2'd1: begin
              buf_q  <= mem_rsp_data[AW-1:0];
              widx_q <= 2'd2;
              state  <= W_RDREQ;
            end
            default: begin
              link_q <= mem_rsp_data[AW-1:0];
              state  <= W_MOVE;
            end
          endcase
        end
        W_MOVE:  if (fm_start_ready) state <= W_FRAME;
        W_FRAME: if (fm_done_valid) begin
          stat_q <= fm_done_status;
          state  <= W_WSTAT;
        end
        W_WSTAT: if (mem_req_ready) state <= W_WCTRL;
        W_WCTRL: if (mem_req_ready) begin
          if (ctrl_q[LINK_BIT]) begin
            base_q      <= link_q;
            widx_q      <= 2'd0;
            first_q     <= 1'b0;
            poll_link_q <= ctrl_q[POLL_BIT];
            state       <= W_RDREQ;
          end else begin
            state <= W_IDLE;
          end
        end
        W_GAP: begin
          if (gap_cnt == '0) begin
            widx_q <= 2'd0;
            state  <= W_RDREQ;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
  import dchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int GAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              fm_start_valid,
  input  logic              fm_start_ready,
  output logic [AW-1:0]     fm_buf_ptr,
  output logic [15:0]       fm_len,
  input  logic              fm_done_valid,
  output logic              fm_done_ready,
  input  logic [15:0]       fm_done_status,
  output logic              irq
);
  logic [AW-1:0]    head_ptr;
  logic             run;
  logic [GAP_W-1:0] poll_gap;
  logic [NIRQ-1:0]  irq_en;
  logic [NIRQ-1:0]  flag_clr;
  logic [NIRQ-1:0]  flags;
  logic [NIRQ-1:0]  ev;
  logic             busy;

  dchain_csr #(.AW(AW), .GAP_W(GAP_W)) u_csr (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .run_clr(ev[IRQ_CHAIN]), .busy, .flags,
    .head_ptr, .run, .poll_gap, .irq_en, .flag_clr
  );

  dchain_walker #(.AW(AW), .GAP_W(GAP_W)) u_walk (
    .clk, .rst_n, .run, .head_ptr, .poll_gap,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data,
    .fm_start_valid, .fm_start_ready, .fm_buf_ptr, .fm_len,
    .fm_done_valid, .fm_done_ready, .fm_done_status,
    .ev, .busy
  );

  dchain_irq u_irq (
    .clk, .rst_n, .ev, .clr(flag_clr), .en(irq_en), .flags, .irq
  );
endmodule

// File: rtl/dchain_sva.sv
module dchain_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          fm_start_valid,
  input logic          fm_start_ready,
  input logic [AW-1:0] fm_buf_ptr,
  input logic [15:0]   fm_len,
  input logic          run,
  input logic [2:0]    ev,
  input logic [2:0]    flags,
  input logic [2:0]    irq_en,
  input logic          irq
);
  a_r3_owner_returned: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |-> (mem_req_write && !mem_req_wdata[31]));

  a_r4_last_both: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[0] && !mem_req_wdata[30]) |-> ev[2]);

  a_r8_run_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[2] && !(reg_we && reg_addr == 3'd1)) |=> !run);

  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> flags[0]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd3) |=> ((flags & $past(flags)) == $past(flags)));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & irq_en) == 3'b000) |-> !irq);

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r11_fm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_start_valid && !fm_start_ready) |=>
      (fm_start_valid && $stable(fm_buf_ptr) && $stable(fm_len)));
endmodule

bind dchain_dma dchain_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .fm_start_valid(fm_start_valid), .fm_start_ready(fm_start_ready),
  .fm_buf_ptr(fm_buf_ptr), .fm_len(fm_len),
  .run(run), .ev(ev), .flags(flags), .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_dchain_dma.sv
`timescale 1ns/1ps
module tb_dchain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fm_start_valid, fm_done_ready;
  logic        fm_start_ready = 1'b0;
  logic [31:0] fm_buf_ptr;
  logic [15:0] fm_len;
  logic        fm_done_valid = 1'b0;
  logic [15:0] fm_done_status = '0;
  logic        irq;

  always #2 clk = ~clk;

  dchain_dma dut (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] mem [0:63];
  logic [31:0] exp_buf [0:31];
  logic [15:0] exp_len [0:31];
  int exp_n = 0, got_n = 0, nreq = 0;
  logic [31:0] poll_addr = 32'hFFFF_FFFF;
  int poll_reads = 0;

  function automatic logic [15:0] st_fn(input logic [31:0] b, input logic [15:0] l);
    return l ^ b[15:0] ^ 16'hA5C3;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  initial begin
    logic acc, wr, pend, stall;
    logic [31:0] a, d, pa, rdat;
    int dly;
    pend = 0; stall = 0; pa = 0; dly = 0; rdat = 0;
    forever begin
      @(negedge clk);
      if (stall) begin
        check("R11 mem request held", {31'd0, mem_req_valid}, 32'd1);
        check("R11 mem address stable", mem_req_addr, pa);
      end
      acc = mem_req_valid && mem_req_ready;
      stall = mem_req_valid && !mem_req_ready;
      pa = mem_req_addr;
      wr = mem_req_write; a = mem_req_addr; d = mem_req_wdata;
      if (mem_req_valid) nreq++;
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rdat; pend = 0; end
        else dly--;
      end
      if (acc) begin
        if (wr) mem[a[7:2]] = d;
        else begin
          pend = 1; dly = $urandom % 3; rdat = mem[a[7:2]];
          if (a == poll_addr) poll_reads++;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
    end
  end

  // frame mover model and order monitor (R2)
  initial begin
    logic st, dn, pend;
    logic [31:0] b;
    logic [15:0] l;
    int dly;
    pend = 0; dly = 0; b = 0; l = 0;
    forever begin
      @(negedge clk);
      st = fm_start_valid && fm_start_ready;
      dn = fm_done_valid && fm_done_ready;
      if (st) begin
        if (got_n < exp_n) begin
          check("R2 frame buffer pointer", fm_buf_ptr, exp_buf[got_n]);
          check("R2 frame length", {16'd0, fm_len}, {16'd0, exp_len[got_n]});
        end else check("R2 unexpected frame start", 32'd1, 32'd0);
        got_n++; b = fm_buf_ptr; l = fm_len;
      end
      @(posedge clk); #1;
      if (dn) fm_done_valid = 1'b0;
      if (st) begin pend = 1; dly = $urandom % 5; end
      else if (pend && !fm_done_valid) begin
        if (dly == 0) begin fm_done_valid = 1'b1; fm_done_status = st_fn(b, l); pend = 0; end
        else dly--;
      end
      fm_start_ready = ($urandom % 3) != 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit v, input bit lk, input bit pl, input logic [15:0] l);
    return {v, lk, pl, 13'd0, l};
  endfunction

  task automatic put_desc(input int s, input logic [31:0] ctrl, input logic [31:0] b, input int nxt);
    mem[s*4] = ctrl; mem[s*4+1] = b; mem[s*4+2] = 32'(nxt*16); mem[s*4+3] = 32'hDEAD_0000;
  endtask

  task automatic expect_frame(input logic [31:0] b, input logic [15:0] l);
    exp_buf[exp_n] = b; exp_len[exp_n] = l; exp_n++;
  endtask

  task automatic wait_chain(input string tag);
    logic [31:0] f;
    int t;
    f = 0; t = 0;
    while (!f[2] && t < 3000) begin rd(3'd3, f); t++; end
    check({tag, " chain-done reached"}, {31'd0, f[2]}, 32'd1);
    repeat (2) @(posedge clk);
  endtask

  task automatic check_done_desc(input string tag, input int s, input logic [31:0] ctrl);
    check({tag, " status word"}, mem[s*4+3], {16'd0, st_fn(mem[s*4+1], ctrl[15:0])});
    check({tag, " owner bit cleared"}, mem[s*4], ctrl & 32'h7FFF_FFFF);
  endtask

  task automatic start_chain(input int s);
    wr(3'd3, 32'h7);
    exp_n = 0; got_n = 0;
    wr(3'd0, 32'(s*16));
    wr(3'd1, 32'd1);
  endtask

  logic [31:0] c [0:3];
  logic [31:0] v;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    void'($urandom(32'h1234));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state and idle behaviour
    rd(3'd3, v); check("R1 flags after reset", v, 32'd0);
    rd(3'd1, v); check("R1 run after reset", v, 32'd0);
    rd(3'd0, v); check("R1 head after reset", v, 32'd0);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    nreq = 0;
    repeat (20) @(posedge clk);
    check("R1 no request while run is 0", 32'(nreq), 32'd0);
    check("R1 no frame start while idle", {31'd0, fm_start_valid}, 32'd0);

    // R2 R3 R4 open chain 1 -> 4 -> 2
    c[0] = mk_ctrl(1, 1, 0, 16'd64);  put_desc(1, c[0], 32'h1000_0100, 4);
    c[1] = mk_ctrl(1, 1, 1, 16'd300); put_desc(4, c[1], 32'h1000_0200, 2);
    c[2] = mk_ctrl(1, 0, 0, 16'd9);   put_desc(2, c[2], 32'h1000_0300, 0);
    wr(3'd2, 32'd3); wr(3'd4, 32'd0);
    start_chain(1);
    expect_frame(32'h1000_0100, 16'd64);
    expect_frame(32'h1000_0200, 16'd300);
    expect_frame(32'h1000_0300, 16'd9);
    wait_chain("R4");
    check("R2 frame count", 32'(got_n), 32'd3);
    check_done_desc("R3 d1", 1, c[0]);
    check_done_desc("R3 d4", 4, c[1]);
    check_done_desc("R3 d2", 2, c[2]);
    rd(3'd3, v); check("R4 flags frame-done and chain-done", v, 32'd5);
    rd(3'd1, v); check("R8 run self-cleared, not busy", v, 32'd0);
    check("R10 irq low with mask 0", {31'd0, irq}, 32'd0);

    // R9 R10 mask and write-one-to-clear
    wr(3'd4, 32'd4); #1; check("R10 irq with chain-done enabled", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'd1); rd(3'd3, v); check("R9 clear only bit 0", v, 32'd4);
    wr(3'd3, 32'd0); rd(3'd3, v); check("R9 writing 0 keeps flags", v, 32'd4);
    wr(3'd4, 32'd3); #1; check("R10 irq low when pending flag masked", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'd0);

    // R5 invalid linked descriptor, no polling
    c[0] = mk_ctrl(1, 1, 0, 16'd77); put_desc(5, c[0], 32'h2000_0000, 6);
    c[1] = mk_ctrl(0, 0, 0, 16'd5);  put_desc(6, c[1], 32'h2000_0040, 0);
    start_chain(5);
    expect_frame(32'h2000_0000, 16'd77);
    wait_chain("R5");
    check("R5 one frame only", 32'(got_n), 32'd1);
    rd(3'd3, v); check("R5 flags all three", v, 32'd7);
    check("R5 invalid descriptor untouched", mem[6*4], c[1]);
    check("R5 invalid status untouched", mem[6*4+3], 32'hDEAD_0000);

    // R6 polling a linked descriptor until it turns valid
    c[0] = mk_ctrl(1, 1, 1, 16'd120); put_desc(7, c[0], 32'h3000_0000, 8);
    c[1] = mk_ctrl(0, 0, 0, 16'd33);  put_desc(8, c[1], 32'h3000_0080, 0);
    wr(3'd2, 32'd20);
    poll_addr = 32'(8*16); poll_reads = 0;
    start_chain(7);
    expect_frame(32'h3000_0000, 16'd120);
    expect_frame(32'h3000_0080, 16'd33);
    repeat (150) @(posedge clk);
    rd(3'd3, v); check("R6 next-invalid set, no chain-done", v & 32'd6, 32'd2);
    rd(3'd1, v); check("R8 busy and run while polling", v, 32'd3);
    wr(3'd3, 32'd3);
    repeat (60) @(posedge clk);
    rd(3'd3, v); check("R6 next-invalid raised again by later poll", v, 32'd2);
    check("R6 poll re-reads at least 3", 32'(poll_reads >= 3), 32'd1);
    check("R6 poll re-reads respect gap", 32'(poll_reads <= 10), 32'd1);
    check("R6 no frame from invalid descriptor", 32'(got_n), 32'd1);
    @(posedge clk); #1;
    c[1] = mk_ctrl(1, 0, 0, 16'd33); mem[8*4] = c[1];
    wait_chain("R6");
    check("R6 resumed without new start", 32'(got_n), 32'd2);
    check_done_desc("R6 d8", 8, c[1]);
    poll_addr = 32'hFFFF_FFFF;

    // R7 first descriptor invalid, its own poll bit 0
    c[0] = mk_ctrl(0, 1, 0, 16'd50); put_desc(9, c[0], 32'h4000_0000, 10);
    start_chain(9);
    wait_chain("R7");
    rd(3'd3, v); check("R7 next-invalid and chain-done only", v, 32'd6);
    check("R7 no frame", 32'(got_n), 32'd0);
    check("R7 descriptor untouched", mem[9*4], c[0]);

    // random chains
    for (int r = 0; r < 6; r++) begin
      int n, b0;
      int s [0:3];
      n = 1 + ($urandom % 4);
      b0 = $urandom % 16;
      for (int k = 0; k < 4; k++) s[k] = (b0 + 5*k) % 16;
      wr(3'd2, 32'($urandom % 8));
      for (int k = 0; k < n; k++) begin
        logic [15:0] l;
        logic [31:0] b;
        l = 16'($urandom); b = $urandom;
        c[k] = mk_ctrl(1, k < n-1, 1'($urandom), l);
        put_desc(s[k], c[k], b, (k < n-1) ? s[k+1] : 0);
      end
      start_chain(s[0]);
      for (int k = 0; k < n; k++) expect_frame(mem[s[k]*4+1], c[k][15:0]);
      wait_chain("R2 random");
      check("R2 random frame count", 32'(got_n), 32'(n));
      for (int k = 0; k < n; k++) check_done_desc("R3 random", s[k], c[k]);
      rd(3'd3, v); check("R4 random flags", v, 32'd5);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule